// File: doc/BRIEF.md
# Seconds-Granular Watchdog Timer

This block is a countdown watchdog for a system controller. Software programs it through an indexed configuration port that holds three byte-wide registers: a count register, a control register and a status register. Any nonzero value written to the count register arms the watchdog or reloads it. The count then drops by one for each elapsed time unit. A unit is one second, or one minute when minute mode is selected. Writing zero disarms the watchdog. Reading the count register returns the number of units left.

When the count runs out, the block drives an active-low reset pulse of fixed width and sets a sticky expiry flag in the status register. The control register can also route the same pulse onto a keyboard-reset output. Keyboard or mouse activity can reload a running count when its enable bit is set. A prescaler divides the system clock down to one-second ticks.

There are two synchronous resets. `por` clears everything. `rst` is the system reset that the watchdog pulse normally causes. It clears the count, the control register and the activity enables. It leaves the expiry flag and any pulse already in progress untouched, so software can see after the restart that the watchdog fired.

Top module: `wdt_secs`

## Requirements
- R1: After `por`, the control, count and status registers (indexes 0xF5, 0xF6, 0xF7) all read 0x00, and both `wdt_rst_n` and `kbrst_n` are high.
- R2: A write of 1 to 255 to the count register (0xF6) loads that value, which reads back at once. The first decrement comes TICK_CYCLES clocks after the write edge, and each later decrement follows TICK_CYCLES clocks after the previous one.
- R3: A write of 0 to the count register stops the watchdog. The count stays at 0 and no expiry happens, however long the wait.
- R4: When the count steps from 1 to 0, the count stays at 0, status bit 4 (mask 0x10) becomes 1, and `wdt_rst_n` goes low in the next cycle for exactly PULSE_W clocks.
- R5: Writing the status register with bit 4 at 0 clears the expiry flag. Writing bit 4 as 1 leaves the flag unchanged.
- R6: Keyboard activity (`kbd_act`) reloads a running count to the last nonzero value written, and restarts the prescaler, when status bit 6 (0x40) or control bit 2 (0x04) is set. Mouse activity (`mouse_act`) does the same when status bit 7 (0x80) is set. Activity without its enable bit, or while the count is 0, has no effect.
- R7: With control bit 1 (0x02) set at expiry, `kbrst_n` goes low together with `wdt_rst_n` for the same PULSE_W clocks. With it clear, `kbrst_n` stays high.
- R8: With control bit 3 (0x08) set, each count unit lasts MIN_UNITS one-second ticks (MIN_UNITS × TICK_CYCLES clocks).
- R9: Writes to any index other than 0xF5, 0xF6 and 0xF7 are ignored, and reads of those other indexes return 0x00.
- R10: `rst` clears the count, the control register and status bits 6 and 7, but keeps the status bit 4 expiry flag. `por` clears the flag as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, synchronous, active high, clears all state |
| rst | input | 1 | System reset, synchronous, active high, keeps the expiry flag |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 8 | Register index |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_idx` (combinational) |
| kbd_act | input | 1 | Keyboard activity pulse |
| mouse_act | input | 1 | Mouse activity pulse |
| wdt_rst_n | output | 1 | Active-low watchdog reset pulse |
| kbrst_n | output | 1 | Active-low keyboard-reset pulse |

## Verification
A wrong count shows up on the count readback no later than the next decrement, which is TICK_CYCLES clocks away. A prescaler that was not restarted shifts that decrement, so readbacks taken one cycle on each side of the expected edge catch it. A bad expiry decision or a wrong pulse length shows up on `wdt_rst_n` within PULSE_W + 1 cycles of the final decrement. A flag that was lost or wrongly cleared stays wrong in the status readback until software writes the status register.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam logic [7:0] IDX_CTRL = 8'hF5;
    localparam logic [7:0] IDX_CNT  = 8'hF6;
    localparam logic [7:0] IDX_STAT = 8'hF7;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    // control byte: bit3 minute units, bit2 keyboard reload, bit1 route to kbd reset
    typedef struct packed {
        logic [3:0] spare_hi;
        logic       minute_mode;
        logic       kbd_reload;
        logic       kbrst_en;
        logic       spare_lo;
    } ctrl_t;

    // status byte: bit7 mouse reload, bit6 keyboard reload, bit4 expired
    typedef struct packed {
        logic mouse_reload;
        logic kbd_reload;
        logic expired;
    } stat_t;

    function automatic reg_sel_e decode_idx(input logic [7:0] idx);
        case (idx)
            IDX_CTRL: return SEL_CTRL;
            IDX_CNT:  return SEL_CNT;
            IDX_STAT: return SEL_STAT;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic logic [7:0] stat_byte(input stat_t s);
        return {s.mouse_reload, s.kbd_reload, 1'b0, s.expired, 4'b0000};
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       por,
    input  logic       rst,
    input  logic       ctrl_we,
    input  logic       stat_we,
    input  logic       flag_clr,
    input  logic [7:0] wdata,
    input  logic       expire,
    output ctrl_t      ctrl_q,
    output stat_t      stat_q
);

    always_ff @(posedge clk) begin
        if (por) begin
            ctrl_q <= '0;
            stat_q <= '0;
        end else if (rst) begin
            ctrl_q              <= '0;
            stat_q.mouse_reload <= 1'b0;
            stat_q.kbd_reload   <= 1'b0;
        end else begin
            if (ctrl_we) begin
                ctrl_q <= ctrl_t'(wdata);
            end
            if (stat_we) begin
                stat_q.mouse_reload <= wdata[7];
                stat_q.kbd_reload   <= wdata[6];
            end
            if (flag_clr) begin
                stat_q.expired <= 1'b0;
            end
            if (expire) begin
                stat_q.expired <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdt_ticker.sv
module wdt_ticker #(
    parameter int TICK_CYCLES = 100_000_000,
    parameter int MIN_UNITS   = 60
) (
    input  logic clk,
    input  logic clr,
    input  logic minute_mode,
    output logic unit_tick
);

    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] P_LAST = PW'(TICK_CYCLES - 1);

    logic [PW-1:0] presc_q;
    logic          sec_tick;

    assign sec_tick = (presc_q == P_LAST);

    always_ff @(posedge clk) begin
        if (clr) begin
            presc_q <= '0;
        end else if (sec_tick) begin
            presc_q <= '0;
        end else begin
            presc_q <= presc_q + 1'b1;
        end
    end

    generate
        if (MIN_UNITS > 1) begin : g_minute
            localparam int MW = $clog2(MIN_UNITS);
            localparam logic [MW-1:0] M_LAST = MW'(MIN_UNITS - 1);
            logic [MW-1:0] sub_q;

            always_ff @(posedge clk) begin
                if (clr || !minute_mode) begin
                    sub_q <= '0;
                end else if (sec_tick) begin
                    sub_q <= (sub_q == M_LAST) ? '0 : sub_q + 1'b1;
                end
            end

            assign unit_tick = sec_tick && (!minute_mode || (sub_q == M_LAST));
        end else begin : g_flat
            logic unused_mode;
            assign unused_mode = minute_mode;
            assign unit_tick   = sec_tick;
        end
    endgenerate

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter (
    input  logic       clk,
    input  logic       rst_any,
    input  logic       cnt_we,
    input  logic [7:0] wdata,
    input  logic       unit_tick,
    input  logic       kbd_act,
    input  logic       mouse_act,
    input  logic       kbd_en,
    input  logic       mouse_en,
    output logic [7:0] cnt_q,
    output logic       act_reload,
    output logic       restart,
    output logic       expire
);

    logic [7:0] reload_q;
    logic       running;

    assign running    = (cnt_q != 8'd0);
    assign act_reload = running && !cnt_we &&
                        ((kbd_act && kbd_en) || (mouse_act && mouse_en));
    assign restart    = cnt_we || act_reload;
    assign expire     = !rst_any && !restart && unit_tick && (cnt_q == 8'd1);

    always_ff @(posedge clk) begin
        if (rst_any) begin
            cnt_q    <= '0;
            reload_q <= '0;
        end else if (cnt_we) begin
            cnt_q <= wdata;
            if (wdata != 8'd0) begin
                reload_q <= wdata;
            end
        end else if (act_reload) begin
            cnt_q <= reload_q;
        end else if (unit_tick && running) begin
            cnt_q <= cnt_q - 8'd1;
        end
    end

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int PULSE_W = 16
) (
    input  logic clk,
    input  logic por,
    input  logic fire,
    input  logic route_kb,
    output logic out_n,
    output logic kb_n
);

    localparam int CW = $clog2(PULSE_W + 1);
    localparam logic [CW-1:0] W_LOAD = CW'(PULSE_W);

    logic [CW-1:0] left_q;
    logic          kb_q;
    logic          active;

    always_ff @(posedge clk) begin
        if (por) begin
            left_q <= '0;
            kb_q   <= 1'b0;
        end else if (fire) begin
            left_q <= W_LOAD;
            kb_q   <= route_kb;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign active = (left_q != '0);
    assign out_n  = !active;
    assign kb_n   = !(active && kb_q);

endmodule

// File: rtl/wdt_secs.sv
module wdt_secs
    import wdt_pkg::*;
#(
    parameter int TICK_CYCLES = 100_000_000,
    parameter int MIN_UNITS   = 60,
    parameter int PULSE_W     = 16
) (
    input  logic       clk,
    input  logic       por,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [7:0] cfg_idx,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       kbd_act,
    input  logic       mouse_act,
    output logic       wdt_rst_n,
    output logic       kbrst_n
);

    reg_sel_e   sel;
    ctrl_t      ctrl_q;
    stat_t      stat_q;
    logic [7:0] cnt_q;
    logic       rst_any;
    logic       cnt_we;
    logic       ctrl_we;
    logic       stat_we;
    logic       flag_clr;
    logic       act_reload;
    logic       restart;
    logic       expire;
    logic       unit_tick;

    assign sel      = decode_idx(cfg_idx);
    assign rst_any  = por || rst;
    assign cnt_we   = cfg_we && (sel == SEL_CNT);
    assign ctrl_we  = cfg_we && (sel == SEL_CTRL);
    assign stat_we  = cfg_we && (sel == SEL_STAT);
    assign flag_clr = stat_we && !cfg_wdata[4];

    wdt_regs u_regs (
        .clk      (clk),
        .por      (por),
        .rst      (rst),
        .ctrl_we  (ctrl_we),
        .stat_we  (stat_we),
        .flag_clr (flag_clr),
        .wdata    (cfg_wdata),
        .expire   (expire),
        .ctrl_q   (ctrl_q),
        .stat_q   (stat_q)
    );

    wdt_ticker #(
        .TICK_CYCLES (TICK_CYCLES),
        .MIN_UNITS   (MIN_UNITS)
    ) u_ticker (
        .clk         (clk),
        .clr         (rst_any || restart),
        .minute_mode (ctrl_q.minute_mode),
        .unit_tick   (unit_tick)
    );

    wdt_counter u_counter (
        .clk        (clk),
        .rst_any    (rst_any),
        .cnt_we     (cnt_we),
        .wdata      (cfg_wdata),
        .unit_tick  (unit_tick),
        .kbd_act    (kbd_act),
        .mouse_act  (mouse_act),
        .kbd_en     (stat_q.kbd_reload || ctrl_q.kbd_reload),
        .mouse_en   (stat_q.mouse_reload),
        .cnt_q      (cnt_q),
        .act_reload (act_reload),
        .restart    (restart),
        .expire     (expire)
    );

    wdt_pulse #(
        .PULSE_W (PULSE_W)
    ) u_pulse (
        .clk      (clk),
        .por      (por),
        .fire     (expire),
        .route_kb (ctrl_q.kbrst_en),
        .out_n    (wdt_rst_n),
        .kb_n     (kbrst_n)
    );

    always_comb begin
        case (sel)
            SEL_CTRL: cfg_rdata = ctrl_q;
            SEL_CNT:  cfg_rdata = cnt_q;
            SEL_STAT: cfg_rdata = stat_byte(stat_q);
            default:  cfg_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/wdt_secs_chk.sv
module wdt_secs_chk #(
    parameter int PULSE_W = 16
) (
    input logic       clk,
    input logic       por,
    input logic       rst,
    input logic       cnt_we,
    input logic       flag_clr,
    input logic       act_reload,
    input logic [7:0] cnt,
    input logic       expired,
    input logic       wdt_rst_n,
    input logic       kbrst_n
);

    int low_run;

    always_ff @(posedge clk) begin
        if (por) begin
            low_run <= 0;
        end else if (!wdt_rst_n) begin
            low_run <= low_run + 1;
        end else begin
            low_run <= 0;
        end
    end

    // R4: the reset pulse never outlasts its width
    p_pulse_max_r4: assert property (@(posedge clk) disable iff (por)
        low_run <= PULSE_W);

    // R4: the pulse is released after exactly its width
    p_pulse_exact_r4: assert property (@(posedge clk) disable iff (por)
        $rose(wdt_rst_n) |-> (low_run == PULSE_W));

    // R4: a new pulse always comes with the expiry flag
    p_fall_flags_r4: assert property (@(posedge clk) disable iff (por)
        $fell(wdt_rst_n) |-> expired);

    // R5 / R10: the flag drops only through a software clear
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (por)
        (expired && !flag_clr) |=> expired);

    // R7: the keyboard reset is never low without the watchdog pulse
    p_kb_inside_r7: assert property (@(posedge clk) disable iff (por)
        !kbrst_n |-> !wdt_rst_n);

    // R3: a stopped counter stays stopped until it is written
    p_stop_holds_r3: assert property (@(posedge clk) disable iff (por || rst)
        ((cnt == 8'd0) && !cnt_we) |=> (cnt == 8'd0));

    // R2: without a load the count only holds or steps down by one
    p_step_r2: assert property (@(posedge clk) disable iff (por || rst)
        (!cnt_we && !act_reload) |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) - 8'd1)));

endmodule

bind wdt_secs wdt_secs_chk #(
    .PULSE_W (PULSE_W)
) u_chk (
    .clk        (clk),
    .por        (por),
    .rst        (rst),
    .cnt_we     (cnt_we),
    .flag_clr   (flag_clr),
    .act_reload (act_reload),
    .cnt        (cnt_q),
    .expired    (stat_q.expired),
    .wdt_rst_n  (wdt_rst_n),
    .kbrst_n    (kbrst_n)
);

// File: tb/wdt_secs_tb.sv
`timescale 1ns/1ps
module wdt_secs_tb;

    localparam int TICK = 8;
    localparam int MINU = 60;
    localparam int PW   = 16;

    localparam int K_RD  = 0;
    localparam int K_WDT = 1;
    localparam int K_KB  = 2;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       rst = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_idx = 8'h00;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       kbd_act = 1'b0;
    logic       mouse_act = 1'b0;
    logic       wdt_rst_n;
    logic       kbrst_n;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    logic done = 1'b0;

    typedef struct {
        int         due;
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    item_t mit;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_secs #(
        .TICK_CYCLES (TICK),
        .MIN_UNITS   (MINU),
        .PULSE_W     (PW)
    ) u_dut (
        .clk       (clk),
        .por       (por),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .kbd_act   (kbd_act),
        .mouse_act (mouse_act),
        .wdt_rst_n (wdt_rst_n),
        .kbrst_n   (kbrst_n)
    );

    // monitor: compares every expected item due in this cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            logic [7:0] act;
            mit = q.pop_front();
            case (mit.kind)
                K_RD:    act = cfg_rdata;
                K_WDT:   act = {7'd0, wdt_rst_n};
                default: act = {7'd0, kbrst_n};
            endcase
            n_chk++;
            if (mit.due != cyc || act !== mit.exp) begin
                n_bad++;
                $display("FAIL %s cycle %0d: actual=%h expected=%h", mit.tag, cyc, act, mit.exp);
            end
        end
    end

    task automatic goto(input int n);
        while (cyc < n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] data, output int le);
        cfg_idx   = idx;
        cfg_wdata = data;
        cfg_we    = 1'b1;
        le        = cyc + 1;
        goto(cyc + 1);
        cfg_we    = 1'b0;
    endtask

    task automatic wrq(input logic [7:0] idx, input logic [7:0] data);
        int le;
        wr(idx, data, le);
    endtask

    task automatic rd(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        item_t it;
        cfg_idx = idx;
        it.due = cyc; it.kind = K_RD; it.exp = exp; it.tag = tag;
        q.push_back(it);
        goto(cyc + 1);
    endtask

    task automatic pin(input int kind, input logic val, input string tag);
        item_t it;
        it.due = cyc; it.kind = kind; it.exp = {7'd0, val}; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic act(input logic k, input logic m);
        kbd_act   = k;
        mouse_act = m;
        goto(cyc + 1);
        kbd_act   = 1'b0;
        mouse_act = 1'b0;
    endtask

    initial begin
        int L;
        int L2;
        goto(3);
        por = 1'b0;
        goto(4);

        // R1: reset state
        pin(K_WDT, 1'b1, "R1 wdt_rst_n");
        pin(K_KB, 1'b1, "R1 kbrst_n");
        rd(8'hF5, 8'h00, "R1 ctrl");
        rd(8'hF6, 8'h00, "R1 count");
        rd(8'hF7, 8'h00, "R1 status");

        // R2 / R4: load 3, count down to expiry
        wr(8'hF6, 8'd3, L);
        rd(8'hF6, 8'd3, "R2 load readback");
        goto(L + TICK - 1);
        rd(8'hF6, 8'd3, "R2 before first tick");
        rd(8'hF6, 8'd2, "R2 first decrement");
        goto(L + 3 * TICK - 1);
        pin(K_WDT, 1'b1, "R4 no pulse before zero");
        rd(8'hF6, 8'd1, "R2 last unit");
        pin(K_WDT, 1'b0, "R4 pulse starts");
        pin(K_KB, 1'b1, "R7 kbrst idle when not routed");
        rd(8'hF6, 8'd0, "R4 count stays zero");
        rd(8'hF7, 8'h10, "R4 expiry flag");
        goto(L + 3 * TICK + PW - 1);
        pin(K_WDT, 1'b0, "R4 pulse last cycle");
        goto(L + 3 * TICK + PW);
        pin(K_WDT, 1'b1, "R4 pulse released");
        pin(K_KB, 1'b1, "R7 kbrst stays high");

        // R5: flag clear semantics
        wrq(8'hF7, 8'h10);
        rd(8'hF7, 8'h10, "R5 write 1 keeps flag");
        wrq(8'hF7, 8'h00);
        rd(8'hF7, 8'h00, "R5 write 0 clears flag");

        // R2: further load values
        wrq(8'hF6, 8'd255);
        rd(8'hF6, 8'd255, "R2 load 255");
        wrq(8'hF6, 8'h80);
        rd(8'hF6, 8'h80, "R2 load 0x80");

        // R3: stop
        wr(8'hF6, 8'd5, L);
        goto(L + 3);
        wr(8'hF6, 8'd0, L2);
        goto(L2 + 7 * TICK);
        pin(K_WDT, 1'b1, "R3 no pulse when stopped");
        rd(8'hF6, 8'd0, "R3 count stays 0");
        rd(8'hF7, 8'h00, "R3 no expiry flag");

        // R6: keyboard via status bit 6, mouse ignored without bit 7
        wrq(8'hF7, 8'h40);
        wr(8'hF6, 8'd2, L);
        goto(L + 6);
        act(1'b1, 1'b0);
        goto(L + 10);
        act(1'b0, 1'b1);
        goto(L + 14);
        rd(8'hF6, 8'd2, "R6 keyboard reload held");
        rd(8'hF6, 8'd1, "R6 mouse ignored without enable");
        wrq(8'hF6, 8'd0);

        // R6: mouse via status bit 7
        wrq(8'hF7, 8'h80);
        wr(8'hF6, 8'd4, L);
        goto(L + 5);
        act(1'b0, 1'b1);
        goto(L + 13);
        rd(8'hF6, 8'd4, "R6 mouse reload held");
        rd(8'hF6, 8'd3, "R6 mouse reload then step");
        wrq(8'hF6, 8'd0);

        // R6: keyboard via control bit 2
        wrq(8'hF7, 8'h00);
        wrq(8'hF5, 8'h04);
        wr(8'hF6, 8'd2, L);
        goto(L + 4);
        act(1'b1, 1'b0);
        goto(L + 12);
        rd(8'hF6, 8'd2, "R6 ctrl keyboard reload held");
        rd(8'hF6, 8'd1, "R6 ctrl keyboard reload then step");
        wrq(8'hF6, 8'd0);
        act(1'b1, 1'b1);
        rd(8'hF6, 8'd0, "R6 activity ignored when stopped");
        wrq(8'hF5, 8'h00);

        // R7: routed keyboard reset
        wrq(8'hF5, 8'h02);
        wr(8'hF6, 8'd1, L);
        goto(L + TICK - 1);
        pin(K_KB, 1'b1, "R7 kbrst high before expiry");
        rd(8'hF6, 8'd1, "R7 count before expiry");
        pin(K_KB, 1'b0, "R7 kbrst low at expiry");
        pin(K_WDT, 1'b0, "R7 wdt low at expiry");
        goto(L + TICK + PW - 1);
        pin(K_KB, 1'b0, "R7 kbrst last cycle");
        goto(L + TICK + PW);
        pin(K_KB, 1'b1, "R7 kbrst released");

        // R10: system reset keeps the flag
        wrq(8'hF7, 8'h50);
        wrq(8'hF6, 8'd9);
        rst = 1'b1;
        goto(cyc + 1);
        rst = 1'b0;
        rd(8'hF7, 8'h10, "R10 flag kept, enables cleared");
        rd(8'hF5, 8'h00, "R10 ctrl cleared");
        rd(8'hF6, 8'h00, "R10 count cleared");
        por = 1'b1;
        goto(cyc + 1);
        por = 1'b0;
        rd(8'hF7, 8'h00, "R10 por clears flag");

        // R8: minute mode
        wrq(8'hF5, 8'h08);
        rd(8'hF5, 8'h08, "R9 ctrl readback");
        wr(8'hF6, 8'd1, L);
        goto(L + MINU * TICK - 1);
        rd(8'hF6, 8'd1, "R8 count held for a minute");
        pin(K_WDT, 1'b0, "R8 expiry after a minute");
        rd(8'hF6, 8'd0, "R8 count zero");
        goto(L + MINU * TICK + PW + 4);
        wrq(8'hF5, 8'h00);
        wrq(8'hF7, 8'h00);

        // R9: unknown indexes
        wrq(8'hF4, 8'h55);
        wrq(8'hF8, 8'hAA);
        rd(8'hF4, 8'h00, "R9 read F4");
        rd(8'hF8, 8'h00, "R9 read F8");
        rd(8'hF5, 8'h00, "R9 ctrl untouched");
        rd(8'hF6, 8'h00, "R9 count untouched");
        rd(8'hF7, 8'h00, "R9 status untouched");

        goto(cyc + 3);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 150000 && !done; i++) begin
            @(posedge clk);
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule